// File: doc/BRIEF.md
# Fixed-Head Disk Controller Function/Status Decoder

This block sits between the CPU's programmed I/O pulses and the transfer engine of a head-per-track disk controller. It holds the 18-bit function/status word and the memory-address, disk-address and word-count registers. Each access supplies three pulse bits and a 2-bit subcode. Together they select the actions for that access: clear or test flags, return a register on the read bus, or load a register from the accumulator bus.

After every access and every engine event, the status word is put back into a consistent form. The summary error bit follows the four error flags, done forces busy low, and the interrupt request follows interrupt enable combined with error or done. A status load also tells the transfer engine to start or to stop. Converting the disk address to and from BCD and moving the data are handled outside this block. The engine reports parity, illegal-address, timing, not-ready and done events through a flag-set input.

Top module: `dskc_func_status`

## Requirements
- R1: Status bit positions are fixed as follows: 17 error summary, 16 parity, 15 illegal address, 14 timing, 13 not ready, 12 done, 11 interrupt enable, 10 busy, 9 write select. Bits 8:0 always read as zero.
- R2: Pulse bit 0 with subcode 00 clears bits 17:12 and leaves bits 11:9 as they were.
- R3: Pulse bit 0 with subcode 01 drives skip_o high in the same cycle when error or done is set, and low otherwise.
- R4: Pulse bit 0 with subcode 10 clears the whole status word.
- R5: Pulse bit 1 with subcode 00 places the disk address on rd_data_o, and with subcode 01 it places the status word there. rd_data_o is zero on every other access. Subcode 11 has no effect.
- R6: Pulse bit 1 with subcode 10 loads the memory address from the bus. Pulse bit 2 with subcode 00 loads the disk address. Pulse bit 2 with subcode 01 loads the word count from bus bits 15:0.
- R7: Pulse bit 2 with subcode 10 loads status as (old AND bits 11:9) XOR (bus AND NOT 0x1FF).
- R8: In the cycle after a status load, start_o pulses if the final busy bit is set and xfer_active_i was low, and cancel_o pulses if busy is clear. The two never pulse together.
- R9: The error summary bit always equals the OR of bits 16:13.
- R10: While done is set, busy reads as zero.
- R11: irq_o equals interrupt enable AND (error OR done).
- R12: Reset clears status, disk address, word count and memory address, and deasserts irq_o, start_o and cancel_o.
- R13: Bits 4:0 of eng_set_i set status bits 16:12 in that order. They are applied after the CPU actions of the same cycle.
- R14: Pulse bits 0 and 2 together with subcode 10 clear the status first and then perform the XOR load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | I/O access valid this cycle |
| pulse_i | input | 3 | Pulse bits of the access |
| sub_i | input | 2 | Subcode of the access |
| bus_i | input | 18 | Accumulator bus data |
| eng_set_i | input | 5 | Engine flag events {par, ila, tim, nry, done} |
| xfer_active_i | input | 1 | Transfer engine currently running |
| rd_data_o | output | 18 | Read-back data for the access |
| skip_o | output | 1 | Skip response to the test access |
| ma_o | output | 15 | Memory address register |
| da_o | output | 17 | Disk address register (BCD track/sector) |
| wc_o | output | 16 | Word count register |
| start_o | output | 1 | Start strobe to the transfer engine |
| cancel_o | output | 1 | Cancel strobe to the transfer engine |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a status load that sets busy in the same cycle as an engine done event or an active transfer. In that case the start strobe must be suppressed, or busy must be cleared before the strobe decision is made. The random stimulus drives engine events and xfer_active_i independently of the access stream, so these collisions occur many times. Directed steps force the combined clear-and-load pulse and a done event that lands on a busy word.

// File: rtl/dskc_pkg.sv
package dskc_pkg;
  localparam int STA_W = 18;
  localparam int B_ERR  = 17;
  localparam int B_PAR  = 16;
  localparam int B_NRY  = 13;
  localparam int B_DONE = 12;
  localparam int B_IE   = 11;
  localparam int B_BSY  = 10;
  localparam int B_WR   = 9;
  localparam int ZERO_W = 9;
  localparam int EV_W   = 5;

  typedef enum logic [1:0] {
    SC_ADDR = 2'b00,
    SC_STAT = 2'b01,
    SC_CTRL = 2'b10,
    SC_RSV  = 2'b11
  } subcode_e;

  typedef struct packed {
    logic clr_flags;
    logic test_skip;
    logic clr_all;
    logic rd_da;
    logic rd_sta;
    logic ld_ma;
    logic ld_da;
    logic ld_wc;
    logic ld_sta;
  } cmd_t;
endpackage

// File: rtl/dskc_decode.sv
module dskc_decode
  import dskc_pkg::*;
(
  input  logic       req_i,
  input  logic [2:0] pulse_i,
  input  logic [1:0] sub_i,
  output cmd_t       cmd_o
);
  subcode_e sc;
  logic [2:0] p;

  assign sc = subcode_e'(sub_i);
  assign p  = req_i ? pulse_i : 3'b000;

  always_comb begin
    cmd_o = '0;
    unique case (sc)
      SC_ADDR: begin
        cmd_o.clr_flags = p[0];
        cmd_o.rd_da     = p[1];
        cmd_o.ld_da     = p[2];
      end
      SC_STAT: begin
        cmd_o.test_skip = p[0];
        cmd_o.rd_sta    = p[1];
        cmd_o.ld_wc     = p[2];
      end
      SC_CTRL: begin
        cmd_o.clr_all   = p[0];
        cmd_o.ld_ma     = p[1];
        cmd_o.ld_sta    = p[2];
      end
      default: cmd_o = '0;
    endcase
  end
endmodule

// File: rtl/dskc_ldreg.sv
module dskc_ldreg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/dskc_status.sv
module dskc_status
  import dskc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_t             cmd_i,
  input  logic [STA_W-1:0] bus_i,
  input  logic [EV_W-1:0]  eng_set_i,
  input  logic             xfer_active_i,
  output logic [STA_W-1:0] sta_o,
  output logic             start_o,
  output logic             cancel_o,
  output logic             irq_o
);
  localparam logic [STA_W-1:0] KEEP_M =
    (STA_W'(1) << B_IE) | (STA_W'(1) << B_BSY) | (STA_W'(1) << B_WR);
  localparam logic [STA_W-1:0] LOW_M = STA_W'((1 << ZERO_W) - 1);
  localparam logic [STA_W-1:0] CLRF_M =
    STA_W'(((1 << (EV_W + 1)) - 1) << B_DONE);

  logic [STA_W-1:0] sta_q, raw, nxt;
  logic start_d, cancel_d;

  always_comb begin
    raw = sta_q;
    if (cmd_i.clr_all)        raw = '0;
    else if (cmd_i.clr_flags) raw = raw & ~CLRF_M;
    if (cmd_i.ld_sta)         raw = (raw & KEEP_M) ^ (bus_i & ~LOW_M);
    raw[B_PAR:B_DONE] = raw[B_PAR:B_DONE] | eng_set_i;
    // rederive summary bits
    nxt = raw & ~LOW_M;
    nxt[B_ERR] = |raw[B_PAR:B_NRY];
    if (nxt[B_DONE]) nxt[B_BSY] = 1'b0;
    start_d  = cmd_i.ld_sta &  nxt[B_BSY] & ~xfer_active_i;
    cancel_d = cmd_i.ld_sta & ~nxt[B_BSY];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sta_q    <= '0;
      start_o  <= 1'b0;
      cancel_o <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      sta_q    <= nxt;
      start_o  <= start_d;
      cancel_o <= cancel_d;
      irq_o    <= nxt[B_IE] & (nxt[B_ERR] | nxt[B_DONE]);
    end
  end

  assign sta_o = sta_q;
endmodule

// File: rtl/dskc_func_status.sv
module dskc_func_status
  import dskc_pkg::*;
#(
  parameter int MA_W = 15,
  parameter int DA_W = 17,
  parameter int WC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [2:0]       pulse_i,
  input  logic [1:0]       sub_i,
  input  logic [STA_W-1:0] bus_i,
  input  logic [EV_W-1:0]  eng_set_i,
  input  logic             xfer_active_i,
  output logic [STA_W-1:0] rd_data_o,
  output logic             skip_o,
  output logic [MA_W-1:0]  ma_o,
  output logic [DA_W-1:0]  da_o,
  output logic [WC_W-1:0]  wc_o,
  output logic             start_o,
  output logic             cancel_o,
  output logic             irq_o
);
  cmd_t             cmd;
  logic [STA_W-1:0] sta;

  dskc_decode u_dec (
    .req_i  (req_i),
    .pulse_i(pulse_i),
    .sub_i  (sub_i),
    .cmd_o  (cmd)
  );

  dskc_status u_sta (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd),
    .bus_i        (bus_i),
    .eng_set_i    (eng_set_i),
    .xfer_active_i(xfer_active_i),
    .sta_o        (sta),
    .start_o      (start_o),
    .cancel_o     (cancel_o),
    .irq_o        (irq_o)
  );

  dskc_ldreg #(.W(MA_W)) u_ma (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(cmd.ld_ma),
    .d_i(bus_i[MA_W-1:0]), .q_o(ma_o)
  );

  dskc_ldreg #(.W(DA_W)) u_da (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(cmd.ld_da),
    .d_i(bus_i[DA_W-1:0]), .q_o(da_o)
  );

  dskc_ldreg #(.W(WC_W)) u_wc (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(cmd.ld_wc),
    .d_i(bus_i[WC_W-1:0]), .q_o(wc_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (cmd.rd_da)       rd_data_o = STA_W'(da_o);
    else if (cmd.rd_sta) rd_data_o = sta;
  end

  assign skip_o = cmd.test_skip & (sta[B_ERR] | sta[B_DONE]);
endmodule

// File: rtl/dskc_func_status_chk.sv
module dskc_func_status_chk
  import dskc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [2:0]       pulse_i,
  input logic [1:0]       sub_i,
  input logic [EV_W-1:0]  eng_set_i,
  input logic             xfer_active_i,
  input logic [STA_W-1:0] sta,
  input logic             start_o,
  input logic             cancel_o,
  input logic             irq_o
);
  logic ld_sta, clr_all_only;
  assign ld_sta = req_i && pulse_i[2] && sub_i == 2'b10;
  assign clr_all_only = req_i && pulse_i == 3'b001 && sub_i == 2'b10 && eng_set_i == '0;

  // R1
  low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sta[ZERO_W-1:0] == '0);
  // R9
  err_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sta[B_ERR] == |sta[B_PAR:B_NRY]);
  // R10
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sta[B_DONE] |-> !sta[B_BSY]);
  // R11
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (sta[B_IE] && (sta[B_ERR] || sta[B_DONE])));
  // R8
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && cancel_o));
  // R8
  strobe_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_sta && !xfer_active_i) |=> (start_o || cancel_o));
  // R4
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_only |=> sta == '0);
endmodule

bind dskc_func_status dskc_func_status_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .pulse_i      (pulse_i),
  .sub_i        (sub_i),
  .eng_set_i    (eng_set_i),
  .xfer_active_i(xfer_active_i),
  .sta          (sta),
  .start_o      (start_o),
  .cancel_o     (cancel_o),
  .irq_o        (irq_o)
);

// File: tb/sim_dskc_func_status.sv
`timescale 1ns/1ps
module sim_dskc_func_status;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0;
  logic [2:0] pulse = '0;
  logic [1:0] sub = '0;
  logic [17:0] bus = '0;
  logic [4:0] eng = '0;
  logic xa = 1'b0;
  logic [17:0] rd_data;
  logic skip, start, cancel, irq;
  logic [14:0] ma;
  logic [16:0] da;
  logic [15:0] wc;

  int checks = 0;
  int errors = 0;
  logic [17:0] m_sta = '0;
  logic [16:0] m_da = '0;
  logic [14:0] m_ma = '0;
  logic [15:0] m_wc = '0;
  logic e_start = 0, e_cancel = 0, e_irq = 0;

  always #2.5 clk = ~clk;

  dskc_func_status u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .pulse_i(pulse), .sub_i(sub),
    .bus_i(bus), .eng_set_i(eng), .xfer_active_i(xa), .rd_data_o(rd_data),
    .skip_o(skip), .ma_o(ma), .da_o(da), .wc_o(wc), .start_o(start),
    .cancel_o(cancel), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] norm(input logic [17:0] s);
    logic [17:0] r;
    r = s & 18'o777000;
    r[17] = |s[16:13];
    if (r[12]) r[10] = 1'b0;
    return r;
  endfunction

  task automatic check_regs(input string tag);
    chk({tag, " R11 irq"}, irq, e_irq);
    chk({tag, " R8 start"}, start, e_start);
    chk({tag, " R8 cancel"}, cancel, e_cancel);
    chk({tag, " R6 ma"}, ma, m_ma);
    chk({tag, " R6 da"}, da, m_da);
    chk({tag, " R6 wc"}, wc, m_wc);
  endtask

  // one access: check registered outputs, drive, check same-cycle outputs, update model
  task automatic acc(input string tag, input logic r, input logic [2:0] p, input logic [1:0] s,
                     input logic [17:0] b, input logic [4:0] e, input logic x);
    logic [17:0] ns, exp_rd;
    logic exp_skip;
    @(negedge clk);
    check_regs(tag);
    req = r; pulse = p; sub = s; bus = b; eng = e; xa = x;
    #1;
    exp_rd = '0;
    if (r && p[1] && s == 2'b00) exp_rd = {1'b0, m_da};
    if (r && p[1] && s == 2'b01) exp_rd = m_sta;
    exp_skip = r && p[0] && s == 2'b01 && (m_sta[17] || m_sta[12]);
    chk({tag, " R5 rd_data"}, rd_data, exp_rd);
    chk({tag, " R3 skip"}, skip, exp_skip);
    ns = m_sta;
    if (r && p[0] && s == 2'b10) ns = '0;
    else if (r && p[0] && s == 2'b00) ns = ns & 18'o007777;
    if (r && p[2] && s == 2'b10) ns = (ns & 18'o007000) ^ (b & 18'o777000);
    ns = ns | ({13'd0, e} << 12);
    ns = norm(ns);
    e_start  = r && p[2] && s == 2'b10 && ns[10] && !x;
    e_cancel = r && p[2] && s == 2'b10 && !ns[10];
    e_irq    = ns[11] && (ns[17] || ns[12]);
    if (r && p[1] && s == 2'b10) m_ma = b[14:0];
    if (r && p[2] && s == 2'b00) m_da = b[16:0];
    if (r && p[2] && s == 2'b01) m_wc = b[15:0];
    m_sta = ns;
  endtask

  task automatic rd_sta(input string tag, input logic [17:0] lit);
    acc(tag, 1, 3'b010, 2'b01, '0, '0, 0);
    chk({tag, " literal"}, rd_data, lit);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_d15c));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    // R12 reset state
    rd_sta("R12 reset", 18'o0);
    // R7 R1 XOR load, low bits masked
    acc("R7 load", 1, 3'b100, 2'b10, 18'o007777, 5'd0, 0);
    rd_sta("R7 R1 pattern", 18'o007000);
    acc("R7 load2", 1, 3'b100, 2'b10, 18'o003000, 5'd0, 0);
    rd_sta("R7 R8 xor", 18'o004000);
    // R13 R9 R11 illegal address event
    acc("R13 ila", 0, 3'b000, 2'b00, '0, 5'b01000, 0);
    rd_sta("R13 R9 err", 18'o504000);
    acc("R3 skip", 1, 3'b001, 2'b01, '0, '0, 0);
    // R2 clear flags keeps IE
    acc("R2 clr", 1, 3'b001, 2'b00, '0, '0, 0);
    rd_sta("R2 kept", 18'o004000);
    // R8 busy while engine active: no start
    acc("R8 busy act", 1, 3'b100, 2'b10, 18'o002000, '0, 1);
    rd_sta("R8 busy", 18'o006000);
    // R10 done clears busy
    acc("R10 done", 0, 3'b000, 2'b00, '0, 5'b00001, 0);
    rd_sta("R10 R11", 18'o014000);
    // R4 clear whole
    acc("R4 clrall", 1, 3'b001, 2'b10, '0, '0, 0);
    rd_sta("R4 zero", 18'o0);
    // R14 combined clear and load
    acc("R14 combo", 1, 3'b101, 2'b10, 18'o777777, '0, 0);
    rd_sta("R14 result", 18'o775000);
    // R6 register loads
    acc("R6 ma", 1, 3'b010, 2'b10, 18'o123456, '0, 0);
    acc("R6 da", 1, 3'b100, 2'b00, 18'h1_9979, '0, 0);
    acc("R6 wc", 1, 3'b100, 2'b01, 18'h3_ABCD, '0, 0);
    acc("R5 rdda", 1, 3'b010, 2'b00, '0, '0, 0);
    // R5 reserved subcode does nothing
    acc("R5 rsv", 1, 3'b111, 2'b11, 18'o777777, '0, 0);
    rd_sta("R5 rsv sta", 18'o775000);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] e;
      e = ($urandom % 8 == 0) ? 5'($urandom) : 5'd0;
      acc("rand", 1'($urandom % 4 != 0), 3'($urandom), 2'($urandom), 18'($urandom), e,
          1'($urandom));
    end
    acc("tail", 0, 3'b000, 2'b00, '0, '0, 0);
    @(negedge clk);
    check_regs("tail");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule